// File: doc/BRIEF.md
# Tagged Receive Packet Byte FIFO

This block buffers bytes coming out of a bit-level packet receiver (flag hunting, zero removal and CRC checking happen upstream) until a host fetches them one at a time. Every stored entry carries the byte together with a start-of-packet tag, an end-of-packet tag and a 2-bit packet status code. The host sees all of these with the byte they belong to, so the status of a packet can be read when its end tag appears.

The head entry is always presented on the read outputs (show-ahead). A read strobe removes it. The block raises a level flag when occupancy goes above a host-programmed threshold. If the receiver writes into a full buffer, the byte is dropped and a sticky overrun flag is raised. From then on every write is refused until the host has emptied the buffer completely, so a suspect packet tail cannot be merged with new traffic. A block output tells the receiver when writes will not be taken.

Top module: `rx_tag_fifo`

## Requirements
- R1: The buffer holds 256 entries. `wr_block_o` is low with 255 entries stored and no lock, and high once 256 entries are stored.
- R2: The read outputs always show the oldest stored entry. `rd_data_o`, `rd_sop_o`, `rd_eop_o` and `rd_stat_o` come from the same write. A read strobe while not empty removes that entry, and entries leave in write order.
- R3: A write while 256 entries are stored, with no read strobe in the same cycle, is dropped and sets `ovr_o` from the next cycle.
- R4: After the event in R3, every write is dropped, even when the buffer is no longer full. Writes are taken again from the cycle after the one in which `empty_o` is high. A write in that empty cycle is still dropped.
- R5: `ovr_o` stays high until `ovr_clr_i` is pulsed. If a clear and an overrun event fall in the same cycle, `ovr_o` stays high. Clearing `ovr_o` does not lift the lock of R4.
- R6: A write and a read strobe in the same cycle while full both take effect. The buffer stays at 256 entries and `ovr_o` does not rise.
- R7: `hwm_o` is high exactly when the stored entry count is strictly greater than the 9-bit `hwm_level_i` (0 to 256). With a level of 256 it never rises.
- R8: `empty_o` is high exactly when no entry is stored. A read strobe while empty has no effect.
- R9: Reset empties the buffer, clears `ovr_o` and clears the lock.
- R10: `wr_block_o` is high when the buffer is full or the lock of R4 is active, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Receiver presents a byte this cycle |
| wr_data_i | input | 8 | Byte from receiver |
| wr_sop_i | input | 1 | Byte opens a packet |
| wr_eop_i | input | 1 | Byte closes a packet |
| wr_stat_i | input | 2 | Packet status code attached to the byte |
| wr_block_o | output | 1 | Writes will be dropped (full or locked) |
| rd_strobe_i | input | 1 | Host removes the head entry |
| rd_data_o | output | 8 | Head byte |
| rd_sop_o | output | 1 | Head byte opens a packet |
| rd_eop_o | output | 1 | Head byte closes a packet |
| rd_stat_o | output | 2 | Status code stored with head byte |
| empty_o | output | 1 | No entry stored |
| hwm_level_i | input | 9 | Occupancy threshold |
| hwm_o | output | 1 | Occupancy above threshold |
| ovr_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Clears the overrun flag |

## Verification
The collisions of interest are a write against a read strobe at full occupancy, and an overrun event against the host clear of the overrun flag. The first must count as a normal pass-through. The second must leave the flag set. Both are driven as directed cycles after the buffer has been filled to exactly 256 entries. The flag, the block output and the order of bytes drained afterwards are then compared with a bench model. Long random runs with changing write and read rates reach these collisions again, along with the empty-cycle unlock of R4.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 2;

  typedef struct packed {
    logic [STAT_W-1:0] stat;
    logic              eop;
    logic              sop;
    logic [BYTE_W-1:0] data;
  } fifo_ent_t;
endpackage

// File: rtl/rx_tag_fifo_mem.sv
module rx_tag_fifo_mem
  import rx_tag_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic      clk_i,
  input  logic      we_i,
  input  logic [AW-1:0] waddr_i,
  input  fifo_ent_t wdata_i,
  input  logic [AW-1:0] raddr_i,
  output fifo_ent_t rdata_o
);
  fifo_ent_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // show-ahead: head entry always visible
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rx_tag_fifo_ctrl.sv
module rx_tag_fifo_ctrl #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          rd_strobe_i,
  input  logic          ovr_clr_i,
  output logic          wr_fire_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o,
  output logic          lock_o,
  output logic          ovr_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          lock_q, ovr_q;
  logic          full, empty, rd_fire, wr_fire, ovf_evt;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign rd_fire = rd_strobe_i && !empty;
  assign ovf_evt = wr_valid_i && full && !rd_fire;
  assign wr_fire = wr_valid_i && !lock_q && (!full || rd_fire);

  function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_fire) wptr_q <= nxt_ptr(wptr_q);
      if (rd_fire) rptr_q <= nxt_ptr(rptr_q);
      case ({wr_fire, rd_fire})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      // lock releases only after an observed empty cycle
      if (ovf_evt)    lock_q <= 1'b1;
      else if (empty) lock_q <= 1'b0;
      // set wins over clear
      if (ovf_evt)        ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign wr_fire_o = wr_fire;
  assign waddr_o   = wptr_q;
  assign raddr_o   = rptr_q;
  assign count_o   = cnt_q;
  assign lock_o    = lock_q;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/rx_tag_fifo_wmark.sv
module rx_tag_fifo_wmark #(
  parameter int CW = 9
) (
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] level_i,
  output logic          hwm_o
);
  assign hwm_o = (count_i > level_i);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rx_tag_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_sop_i,
  input  logic              wr_eop_i,
  input  logic [STAT_W-1:0] wr_stat_i,
  output logic              wr_block_o,
  input  logic              rd_strobe_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_sop_o,
  output logic              rd_eop_o,
  output logic [STAT_W-1:0] rd_stat_o,
  output logic              empty_o,
  input  logic [CW-1:0]     hwm_level_i,
  output logic              hwm_o,
  output logic              ovr_o,
  input  logic              ovr_clr_i
);
  logic          wr_fire, lock;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;
  fifo_ent_t     wr_ent, rd_ent;

  assign wr_ent = '{stat: wr_stat_i, eop: wr_eop_i, sop: wr_sop_i, data: wr_data_i};

  rx_tag_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .rd_strobe_i (rd_strobe_i),
    .ovr_clr_i   (ovr_clr_i),
    .wr_fire_o   (wr_fire),
    .waddr_o     (waddr),
    .raddr_o     (raddr),
    .count_o     (count),
    .lock_o      (lock),
    .ovr_o       (ovr_o)
  );

  rx_tag_fifo_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i (waddr),
    .wdata_i (wr_ent),
    .raddr_i (raddr),
    .rdata_o (rd_ent)
  );

  rx_tag_fifo_wmark #(.CW(CW)) u_wmark (
    .count_i (count),
    .level_i (hwm_level_i),
    .hwm_o   (hwm_o)
  );

  assign empty_o    = (count == '0);
  assign wr_block_o = lock || (count == CW'(DEPTH));
  assign rd_data_o  = rd_ent.data;
  assign rd_sop_o   = rd_ent.sop;
  assign rd_eop_o   = rd_ent.eop;
  assign rd_stat_o  = rd_ent.stat;
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          rd_strobe_i,
  input logic          ovr_clr_i,
  input logic          empty_o,
  input logic          hwm_o,
  input logic          ovr_o,
  input logic          wr_block_o,
  input logic [CW-1:0] count_i,
  input logic          lock_i
);
  logic at_full;
  assign at_full = (count_i == CW'(DEPTH));

  assert_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  assert_ovf_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_full && wr_valid_i && !rd_strobe_i) |=> ovr_o);

  assert_locked_no_grow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_block_o && !at_full) |=> (count_i <= $past(count_i)));

  assert_ovr_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  assert_ovr_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_clr_i && !(at_full && wr_valid_i && !rd_strobe_i)) |=> !ovr_o);

  assert_full_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_full && !lock_i && wr_valid_i && rd_strobe_i) |=> at_full);

  assert_hwm_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !hwm_o);

  assert_empty_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !wr_valid_i) |=> empty_o);

  assert_block_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_full |-> wr_block_o);
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .rd_strobe_i (rd_strobe_i),
  .ovr_clr_i   (ovr_clr_i),
  .empty_o     (empty_o),
  .hwm_o       (hwm_o),
  .ovr_o       (ovr_o),
  .wr_block_o  (wr_block_o),
  .count_i     (count),
  .lock_i      (lock)
);

// File: tb/tb_rx_tag_fifo.sv
module tb_rx_tag_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       wr_sop_i = 1'b0, wr_eop_i = 1'b0;
  logic [1:0] wr_stat_i = '0;
  logic       wr_block_o;
  logic       rd_strobe_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_sop_o, rd_eop_o;
  logic [1:0] rd_stat_o;
  logic       empty_o;
  logic [8:0] hwm_level_i = 9'd128;
  logic       hwm_o, ovr_o;
  logic       ovr_clr_i = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [11:0] mq[$];
  bit          m_lock = 0, m_ovr = 0;
  logic [11:0] tag = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_tag_fifo dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_sop_i(wr_sop_i),
    .wr_eop_i(wr_eop_i), .wr_stat_i(wr_stat_i), .wr_block_o(wr_block_o),
    .rd_strobe_i(rd_strobe_i), .rd_data_o(rd_data_o), .rd_sop_o(rd_sop_o),
    .rd_eop_o(rd_eop_o), .rd_stat_o(rd_stat_o), .empty_o(empty_o),
    .hwm_level_i(hwm_level_i), .hwm_o(hwm_o), .ovr_o(ovr_o), .ovr_clr_i(ovr_clr_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hwm(input int cnt, input logic [8:0] lvl);
    return cnt > int'(lvl);
  endfunction

  // drive one cycle, check the state left by earlier cycles, advance model
  task automatic step(input bit wv, input logic [11:0] wd, input bit rs,
                      input bit clr, input logic [8:0] lvl);
    int  cnt;
    bit  full, emp, rdf, ovf, wrf;
    @(negedge clk);
    wr_valid_i = wv;
    {wr_stat_i, wr_eop_i, wr_sop_i, wr_data_i} = wd;
    rd_strobe_i = rs;
    ovr_clr_i = clr;
    hwm_level_i = lvl;
    #1;
    cnt = mq.size();
    chk("R8 empty_o", 32'(empty_o), 32'(cnt == 0));
    chk("R10 wr_block_o", 32'(wr_block_o), 32'(m_lock || cnt == DEPTH));
    chk("R5 ovr_o", 32'(ovr_o), 32'(m_ovr));
    chk("R7 hwm_o", 32'(hwm_o), 32'(exp_hwm(cnt, lvl)));
    if (cnt != 0)
      chk("R2 head entry", 32'({rd_stat_o, rd_eop_o, rd_sop_o, rd_data_o}), 32'(mq[0]));
    full = (cnt == DEPTH);
    emp  = (cnt == 0);
    rdf  = rs && !emp;
    ovf  = wv && full && !rdf;
    wrf  = wv && !m_lock && (!full || rdf);
    if (rdf) void'(mq.pop_front());
    if (wrf) mq.push_back(wd);
    if (ovf) m_lock = 1; else if (emp) m_lock = 0;
    if (ovf) m_ovr = 1; else if (clr) m_ovr = 0;
  endtask

  task automatic idle(input logic [8:0] lvl = 9'd128);
    step(0, '0, 0, 0, lvl);
  endtask

  function automatic logic [11:0] next_tag();
    tag = tag + 12'd37;
    return tag;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    wr_valid_i = 0; rd_strobe_i = 0; ovr_clr_i = 0;
    mq.delete(); m_lock = 0; m_ovr = 0;
    #1;
    chk("R9 empty in reset", 32'(empty_o), 32'd1);
    chk("R9 ovr in reset", 32'(ovr_o), 32'd0);
    chk("R9 block in reset", 32'(wr_block_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    idle();
    chk("R9 empty after reset", 32'(empty_o), 32'd1);

    // R1: fill to 255 then 256
    for (int i = 0; i < DEPTH - 1; i++) step(1, next_tag(), 0, 0, 9'd128);
    idle(9'd255);
    chk("R1 not blocked at 255", 32'(wr_block_o), 32'd0);
    chk("R7 hwm at 255 lvl 255", 32'(hwm_o), 32'd0);
    step(1, next_tag(), 0, 0, 9'd255);
    idle(9'd255);
    chk("R1 blocked at 256", 32'(wr_block_o), 32'd1);
    chk("R7 hwm at 256 lvl 255", 32'(hwm_o), 32'd1);
    idle(9'd256);
    chk("R7 hwm at 256 lvl 256", 32'(hwm_o), 32'd0);

    // R6: write and read while full
    step(1, next_tag(), 1, 0, 9'd128);
    idle();
    chk("R6 no overrun on full r/w", 32'(ovr_o), 32'd0);
    chk("R6 still full", 32'(wr_block_o), 32'd1);

    // R3: write while full without read
    step(1, next_tag(), 0, 0, 9'd128);
    idle();
    chk("R3 overrun set", 32'(ovr_o), 32'd1);

    // R5: clear colliding with a new overrun event
    step(1, next_tag(), 0, 1, 9'd128);
    idle();
    chk("R5 set wins over clear", 32'(ovr_o), 32'd1);
    step(0, '0, 0, 1, 9'd128);
    idle();
    chk("R5 cleared", 32'(ovr_o), 32'd0);

    // R4: locked while not full
    step(0, '0, 1, 0, 9'd128);
    step(1, next_tag(), 0, 0, 9'd128);
    idle();
    chk("R4 blocked below full", 32'(wr_block_o), 32'd1);
    chk("R5 clear did not unlock", 32'(ovr_o), 32'd0);
    while (mq.size() > 0) step(0, '0, 1, 0, 9'd128);
    step(1, next_tag(), 0, 0, 9'd128);   // empty cycle: dropped
    idle();
    chk("R4 write in empty cycle dropped", 32'(empty_o), 32'd1);
    step(1, 12'hA5C, 0, 0, 9'd128);
    idle();
    chk("R4 write accepted after unlock", 32'(empty_o), 32'd0);
    chk("R2 tagged byte returned", 32'({rd_stat_o, rd_eop_o, rd_sop_o, rd_data_o}), 32'h0A5C);
    step(0, '0, 1, 0, 9'd128);
    step(0, '0, 1, 0, 9'd128);           // read while empty
    idle();
    chk("R8 read on empty ignored", 32'(empty_o), 32'd1);

    // random phases
    for (int ph = 0; ph < 16; ph++) begin
      int pw = (ph % 4 == 0) ? 95 : (ph % 4 == 1) ? 20 : (ph % 4 == 2) ? 60 : 50;
      int pr = (ph % 4 == 0) ? 10 : (ph % 4 == 1) ? 90 : (ph % 4 == 2) ? 55 : 50;
      logic [8:0] lvl = 9'($urandom_range(0, 256));
      for (int c = 0; c < 700; c++) begin
        bit wv  = ($urandom_range(0, 99) < pw);
        bit rs  = ($urandom_range(0, 99) < pr);
        bit clr = ($urandom_range(0, 63) == 0);
        if ($urandom_range(0, 99) == 0) lvl = 9'($urandom_range(0, 256));
        step(wv, 12'($urandom), rs, clr, lvl);
      end
      if (ph == 9) do_reset();
    end

    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule